// File: doc/BRIEF.md
# Read-to-Write Bus Turnaround Scheduler

This block sits between a memory controller's request logic and the command pins of a synchronous graphics DRAM. It tracks the read words that are still due on the shared data bus. The tracking uses the cycle each read command was sent, the current read latency and the burst length. When the requester asks for a write or block write while read data is still coming back, the block holds the write back by raising a stall and sending NOP. It raises the byte mask outputs so that, after the part's two-cycle mask latency, late read words stay off the bus. It releases the write only once the bus has been quiet for a full cycle.

Reads and precharges go through the same command port. A newer read replaces the unfinished tail of an older burst. A precharge cuts a burst short. The block keeps its tracking current in both cases, so the write is released as early as the rules allow. With nothing in flight, a write goes out in the same cycle it is requested.

Top module: `rw_turn_sched`

## Requirements
- R1: During and right after reset, cmd_o is NOP (code 0), stall_o is 0, dqm_o is all zeros, and no read word is tracked.
- R2: When rd_req_i is high and wr_req_i is low, cmd_o is READ (code 1) in that cycle. The read words then occupy the bus from cycle T+CL to cycle T+CL+BL-1. T is the issue cycle and CL is cas_lat_i (1 to 3). BL is 1, 2, 4 or 8 for burst_code_i values 0, 1, 2 and 3.
- R3: A write request goes out in the same cycle without a stall when no unmasked read word is on the bus in the cycle before, the same cycle or the cycle after.
- R4: While a write request cannot be issued, stall_o is 1, cmd_o is NOP and dqm_o is all ones.
- R5: A write requested from cycle R is issued in cycle max(R, L+2). L is the last read word actually driven, so at least one idle bus cycle always separates that word from the write.
- R6: A mask raised in cycle c suppresses the read word due in cycle c+2 and no earlier word.
- R7: In the cycle a write is issued, cmd_o is WRITE (code 2) when wr_blk_i is 0 and BLOCK WRITE (code 3) when it is 1, dqm_o equals wr_mask_i, and stall_o is 0.
- R8: Issuing a write clears every pending read word, so a write requested in the next cycle issues at once.
- R9: A read issued in cycle T2 replaces all words of an earlier burst due at or after T2+CL. Earlier words of that burst still count.
- R10: When pre_req_i is high and neither wr_req_i nor rd_req_i is high, cmd_o is PRECHARGE (code 4), and tracked words due at or after P+CL are dropped, where P is the precharge cycle.
- R11: While wr_req_i is high, rd_req_i and pre_req_i are ignored: no READ or PRECHARGE is sent and no read words are added.
- R12: With rd_req_i and pre_req_i both high and no write request, READ is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cas_lat_i | input | 2 | Read latency in cycles (1 to 3) |
| burst_code_i | input | 2 | Burst length code (BL = 2**code) |
| rd_req_i | input | 1 | Read command request |
| pre_req_i | input | 1 | Precharge request |
| wr_req_i | input | 1 | Write request, held until stall_o drops |
| wr_blk_i | input | 1 | Selects block write for the write request |
| wr_mask_i | input | 4 | Byte mask for the write cycle |
| cmd_o | output | 3 | Issued command: 0 NOP, 1 READ, 2 WRITE, 3 BLOCK WRITE, 4 PRECHARGE |
| dqm_o | output | 4 | Byte mask pins |
| stall_o | output | 1 | Write request held back |

## Verification
The bench sweeps every latency and burst length against write requests placed 1 to 10 cycles after a read, with three histories. A single read separates a write released at once, a write delayed by the idle cycle, and a write delayed by masking. A read followed one cycle later by a second read shows whether the replaced tail is dropped while the older head is kept. A read cut by a precharge at each possible point shows whether the dropped words stop holding the write back. In each case the write issue cycle is predicted from max(R, L+2) and compared cycle by cycle with the stall, the mask and the command. Reads sent during a stall, back-to-back writes, an idle write and a read–precharge tie cover the ignore and priority rules.

// File: rtl/rw_turn_pkg.sv
package rw_turn_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_BWRITE = 3'd3,
        CMD_PRE   = 3'd4
    } cmd_e;

    // Number of data words in a burst for a given length code.
    function automatic int burst_words(input logic [1:0] code);
        return 1 << code;
    endfunction

endpackage

// File: rtl/rw_read_tracker.sv
// Keeps one bit per upcoming bus cycle that still carries an unmasked read word.
module rw_read_tracker #(
    parameter int MAX_CL = 3,
    parameter int MAX_BL = 8,
    localparam int WIN = MAX_CL + MAX_BL - 1,
    localparam int CLW = $clog2(MAX_CL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CLW-1:0] cas_lat_i,
    input  logic [1:0]     burst_code_i,
    input  logic           rd_issue_i,
    input  logic           pre_issue_i,
    input  logic           wr_issue_i,
    input  logic           mask_i,
    output logic           bus_near_o
);
    import rw_turn_pkg::*;

    typedef struct packed {
        logic [WIN-1:0] due;    // bit i: word on the bus i cycles from now
        logic           prev;   // a word was on the bus last cycle
    } trk_t;

    trk_t trk_d, trk_q;
    logic [WIN-1:0] shifted;

    always_comb begin
        int lo;
        int hi;
        trk_d   = trk_q;
        shifted = trk_q.due >> 1;
        // Mask now hits the word two cycles ahead (index 1 after the shift).
        if (mask_i) begin
            shifted[1] = 1'b0;
        end
        lo = int'(cas_lat_i) - 1;
        hi = lo + burst_words(burst_code_i) - 1;
        trk_d.prev = trk_q.due[0];
        for (int i = 0; i < WIN; i++) begin
            if (wr_issue_i) begin
                trk_d.due[i] = 1'b0;
            end else if (rd_issue_i) begin
                trk_d.due[i] = (i < lo) ? shifted[i] : (i <= hi);
            end else if (pre_issue_i) begin
                trk_d.due[i] = (i < lo) ? shifted[i] : 1'b0;
            end else begin
                trk_d.due[i] = shifted[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign bus_near_o = trk_q.prev | trk_q.due[0] | trk_q.due[1];

    AST_MASK_TWO_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i && !rd_issue_i) |=> !trk_q.due[1]); // R6

    AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_issue_i |=> (trk_q.due == '0 && !trk_q.prev)); // R8

    AST_WRITE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_issue_i |-> (!trk_q.prev && trk_q.due[1:0] == 2'b00)); // R5

    AST_PRE_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_issue_i && !rd_issue_i && !wr_issue_i && cas_lat_i != '0)
        |=> ((trk_q.due >> ($past(cas_lat_i) - 1'b1)) == '0)); // R10

endmodule

// File: rtl/rw_cmd_gate.sv
// Picks the command of this cycle and drives stall and mask pins.
module rw_cmd_gate #(
    parameter int MASK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_i,
    input  logic              pre_req_i,
    input  logic              wr_req_i,
    input  logic              wr_blk_i,
    input  logic [MASK_W-1:0] wr_mask_i,
    input  logic              bus_near_i,
    output rw_turn_pkg::cmd_e cmd_o,
    output logic [MASK_W-1:0] dqm_o,
    output logic              stall_o,
    output logic              rd_issue_o,
    output logic              pre_issue_o,
    output logic              wr_issue_o
);
    import rw_turn_pkg::*;

    logic wr_go;

    always_comb begin
        wr_go       = wr_req_i && !bus_near_i;
        stall_o     = wr_req_i && bus_near_i;
        rd_issue_o  = !wr_req_i && rd_req_i;
        pre_issue_o = !wr_req_i && !rd_req_i && pre_req_i;
        wr_issue_o  = wr_go;
        if (wr_go) begin
            cmd_o = wr_blk_i ? CMD_BWRITE : CMD_WRITE;
        end else if (wr_req_i) begin
            cmd_o = CMD_NOP;
        end else if (rd_req_i) begin
            cmd_o = CMD_READ;
        end else if (pre_req_i) begin
            cmd_o = CMD_PRE;
        end else begin
            cmd_o = CMD_NOP;
        end
        if (wr_go) begin
            dqm_o = wr_mask_i;
        end else if (stall_o) begin
            dqm_o = '1;
        end else begin
            dqm_o = '0;
        end
    end

    AST_STALL_HOLDS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (cmd_o == CMD_NOP && dqm_o == '1)); // R4

    AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req_i |-> !stall_o); // R11

    AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_issue_o, pre_issue_o, wr_issue_o}) <= 1); // R12

endmodule

// File: rtl/rw_turn_sched.sv
module rw_turn_sched #(
    parameter int MASK_W = 4,
    parameter int MAX_CL = 3,
    parameter int MAX_BL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cas_lat_i,
    input  logic [1:0]        burst_code_i,
    input  logic              rd_req_i,
    input  logic              pre_req_i,
    input  logic              wr_req_i,
    input  logic              wr_blk_i,
    input  logic [MASK_W-1:0] wr_mask_i,
    output logic [2:0]        cmd_o,
    output logic [MASK_W-1:0] dqm_o,
    output logic              stall_o
);
    import rw_turn_pkg::*;

    cmd_e cmd;
    logic rd_issue, pre_issue, wr_issue, bus_near;

    rw_cmd_gate #(.MASK_W(MASK_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req_i   (rd_req_i),
        .pre_req_i  (pre_req_i),
        .wr_req_i   (wr_req_i),
        .wr_blk_i   (wr_blk_i),
        .wr_mask_i  (wr_mask_i),
        .bus_near_i (bus_near),
        .cmd_o      (cmd),
        .dqm_o      (dqm_o),
        .stall_o    (stall_o),
        .rd_issue_o (rd_issue),
        .pre_issue_o(pre_issue),
        .wr_issue_o (wr_issue)
    );

    rw_read_tracker #(.MAX_CL(MAX_CL), .MAX_BL(MAX_BL)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .cas_lat_i   (cas_lat_i),
        .burst_code_i(burst_code_i),
        .rd_issue_i  (rd_issue),
        .pre_issue_i (pre_issue),
        .wr_issue_i  (wr_issue),
        .mask_i      (stall_o),
        .bus_near_o  (bus_near)
    );

    assign cmd_o = cmd;

    AST_WRITE_AFTER_STALL_OR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stall_o) && wr_req_i && !stall_o) |-> (cmd_o == 3'd2 || cmd_o == 3'd3)); // R7

endmodule

// File: tb/rw_turn_sched_test.sv
module rw_turn_sched_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cas_lat_i = 2'd1;
    logic [1:0] burst_code_i = 2'd0;
    logic       rd_req_i = 1'b0;
    logic       pre_req_i = 1'b0;
    logic       wr_req_i = 1'b0;
    logic       wr_blk_i = 1'b0;
    logic [3:0] wr_mask_i = 4'h0;
    logic [2:0] cmd_o;
    logic [3:0] dqm_o;
    logic       stall_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    rw_turn_sched uut (
        .clk(clk), .rst_n(rst_n), .cas_lat_i(cas_lat_i), .burst_code_i(burst_code_i),
        .rd_req_i(rd_req_i), .pre_req_i(pre_req_i), .wr_req_i(wr_req_i),
        .wr_blk_i(wr_blk_i), .wr_mask_i(wr_mask_i),
        .cmd_o(cmd_o), .dqm_o(dqm_o), .stall_o(stall_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rd_req_i = 0; pre_req_i = 0; wr_req_i = 0; wr_blk_i = 0; wr_mask_i = 4'h0;
    endtask

    task automatic drain(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            idle_inputs();
        end
    endtask

    // mode 0: single read; 1: second read one cycle later; 2: precharge at cycle p
    task automatic run_case(input int cl, input int blc, input int gap, input int mode, input int p);
        int bl, first, last, lastd, w, got;
        bit done;
        logic [3:0] wm;
        bl = 1 << blc;
        first = cl;
        last = cl + bl - 1;
        if (mode == 1) last = cl + bl;                               // R9
        if (mode == 2 && p + cl - 1 < last) last = p + cl - 1;       // R10
        lastd = (last < gap + 1) ? last : gap + 1;                   // R6: mask from gap hits gap+2
        if (first > gap + 1) w = gap;
        else w = (gap > lastd + 2) ? gap : lastd + 2;                // R5
        wm = 4'(gap * 3 + blc);
        cas_lat_i = 2'(cl);
        burst_code_i = 2'(blc);
        done = 0;
        got = -1;
        for (int c = 0; c < gap + 20 && !done; c++) begin
            @(negedge clk);
            idle_inputs();
            rd_req_i = (c == 0) || (mode == 1 && c == 1);
            pre_req_i = (mode == 2 && c == p);
            if (c >= gap) begin
                wr_req_i = 1;
                wr_blk_i = blc[0];
                wr_mask_i = wm;
                if (mode == 0 && (gap % 2) == 1) rd_req_i = 1;      // R11: ignored
            end
            #1;
            if (c == 0) chk(cmd_o == 3'd1, "R2 read cmd", cmd_o, 1);
            if (mode == 1 && c == 1) chk(cmd_o == 3'd1, "R9 second read cmd", cmd_o, 1);
            if (mode == 2 && c == p) chk(cmd_o == 3'd4, "R10 precharge cmd", cmd_o, 4);
            if (c < gap) begin
                chk(stall_o == 1'b0 && dqm_o == 4'h0, "R2 no stall before request", {stall_o, dqm_o}, 0);
            end else if (stall_o) begin
                chk(cmd_o == 3'd0 && dqm_o == 4'hF, "R4 stalled nop with mask", {cmd_o, dqm_o}, 15);
                chk(c < w, "R5 stall only before issue", c, w);
            end else begin
                got = c;
                done = 1;
                chk(cmd_o == (blc[0] ? 3'd3 : 3'd2), "R7 write code", cmd_o, blc[0] ? 3 : 2);
                chk(dqm_o == wm, "R7 write mask", dqm_o, wm);
            end
        end
        chk(got == w, "R5 R6 write issue cycle", got, w);
        @(negedge clk);
        idle_inputs();
        wr_req_i = 1;
        #1;
        chk(stall_o == 1'b0 && cmd_o == 3'd2, "R8 tracking cleared by write", {stall_o, cmd_o}, 2);
        drain(12);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        bad++;
        total++;
        $display("FAIL watchdog R5 actual=%0d expected=%0d", cycles, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        chk(cmd_o == 3'd0 && stall_o == 0 && dqm_o == 4'h0, "R1 reset outputs", {cmd_o, stall_o, dqm_o}, 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        wr_req_i = 1;
        #1;
        chk(cmd_o == 3'd2 && stall_o == 0, "R1 R3 idle write immediate", {cmd_o, stall_o}, 2);
        drain(2);
        @(negedge clk);
        rd_req_i = 1; pre_req_i = 1;
        #1;
        chk(cmd_o == 3'd1, "R12 read wins over precharge", cmd_o, 1);
        drain(14);
        @(negedge clk);
        pre_req_i = 1; wr_req_i = 1;
        #1;
        chk(cmd_o == 3'd2, "R11 precharge ignored under write", cmd_o, 2);
        drain(2);
        for (int cl = 1; cl <= 3; cl++)
            for (int blc = 0; blc < 4; blc++)
                for (int gap = 1; gap <= 10; gap++) begin
                    run_case(cl, blc, gap, 0, 0);
                    if (gap >= 2) begin
                        run_case(cl, blc, gap, 1, 0);
                        for (int p = 1; p < gap; p++) run_case(cl, blc, gap, 2, p);
                    end
                end
        // R3: a read whose words are long past does not delay a write
        cas_lat_i = 2'd1; burst_code_i = 2'd0;
        @(negedge clk); idle_inputs(); rd_req_i = 1;
        drain(3);
        @(negedge clk); wr_req_i = 1;
        #1;
        chk(cmd_o == 3'd2 && stall_o == 0, "R3 past burst no stall", {cmd_o, stall_o}, 2);
        drain(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule